// File: doc/BRIEF.md
# Cooperative Coprocessor Task Scheduler

This block picks the next task for a coprocessor that runs several streaming tasks in turn. It never takes the coprocessor away from a task. The coprocessor decides when it has reached a switch point. At that point it sends a get-task request with two flags: one says the step just finished got stuck waiting for stream space, the other says the step hit an error. One cycle later the block answers with a task number and that task's configured info word. If no task can run, it answers with an idle indication.

A small task table holds the scheduling data for each task:
- an enable flag,
- a step budget,
- an info word,
- two stream identifiers.

A narrow register write port loads the table, and the table may be rewritten while tasks are running. A task reported as stuck is skipped until a space-update notice arrives for one of its streams. A task reported as failing is switched off until it is re-enabled through the write port. Selection rotates among the runnable tasks. A task keeps the coprocessor for up to its budget of consecutive steps.

Top module: `coop_task_sched`

## Requirements
- R1: After reset no response is signalled, every task is disabled, and a first request answers idle.
- R2: Each request cycle produces exactly one response cycle (`rsp_valid`) on the following cycle. No response appears without a request.
- R3: A new selection scans the runnable tasks in ascending number, wrapping around. The scan starts at the task after the last one selected. After reset the scan starts at task 0.
- R4: A task with budget B (B = 0 counts as 1) is granted at most B consecutive times. After that the scan moves on. If the task is the only runnable one, it is granted again with a fresh budget.
- R5: Setting `req_blocked` marks the task granted last as stuck, and it is skipped. It becomes runnable again when `upd_valid` carries a stream identifier equal to either of its two stream slots.
- R6: A space update whose identifier matches neither stream slot of a stuck task leaves that task stuck.
- R7: Setting `req_error` clears the enable flag of the task granted last. The task stays excluded until the control field is written with bit 0 set.
- R8: When no task is runnable, the response has `rsp_idle` = 1, task 0 and info 0, and no task is held as current. The next selection scans from the task after the last one selected.
- R9: Every non-idle response carries the info word stored for the returned task at the time of the request.
- R10: Clearing a task's enable flag through the write port removes it at the next request, even if it has budget left.
- R11: Write-port field codes in `cfg_fld`:
  - 0 is control: bit 0 is enable, and the write also clears the stuck mark.
  - 1 is budget, in the low BUDGET_W bits.
  - 2 is info.
  - 3 is streams: slot 0 in bits [SID_W-1:0] and slot 1 in bits [2*SID_W-1:SID_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_task | input | TID_W | Task entry to write |
| cfg_fld | input | 2 | Field code (see R11) |
| cfg_wdata | input | INFO_W | Write data |
| upd_valid | input | 1 | Stream space-update notice |
| upd_sid | input | SID_W | Stream identifier of the notice |
| req | input | 1 | Get-task request |
| req_blocked | input | 1 | Previous step was stuck on stream space |
| req_error | input | 1 | Previous step failed |
| rsp_valid | output | 1 | Response strobe |
| rsp_idle | output | 1 | No task runnable |
| rsp_task | output | TID_W | Selected task |
| rsp_info | output | INFO_W | Info word of the selected task |

## Verification
The bench goes after the following corner cases:
- **Budget boundaries.** A zero budget must behave like a budget of one. A design with an off-by-one counter would grant one step too many or too few.
- **Rotation start point.** After an idle period the scan must resume after the last selected task. A design that reset its pointer would restart at task 0.
- **Unblocking.** A stuck task is sent one update for an unrelated stream and one for its own stream. A loose comparison would release it early, and a missed comparison would keep it idle forever.
- **Disabling mid-budget.** A running task that is disabled while it still has budget must lose the coprocessor at once. A design that checked only the budget would keep granting it.
- **Only one runnable task.** When the current task is the only runnable one, it must be re-granted. A design that skipped the current task in the scan would answer idle instead.

// File: rtl/tsk_pkg.sv
package tsk_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL    = 2'd0,
    FLD_BUDGET  = 2'd1,
    FLD_INFO    = 2'd2,
    FLD_STREAMS = 2'd3
  } tsk_fld_e;
endpackage

// File: rtl/tsk_rr_pick.sv
module tsk_rr_pick #(
  parameter int N     = 4,
  parameter int TID_W = 2
) (
  input  logic [N-1:0]     mask,
  input  logic [TID_W-1:0] last,
  output logic             found,
  output logic [TID_W-1:0] idx
);
  // rotating scan: offset 1 first, offset N (the last task itself) at the end
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      if (!found && mask[(int'(last) + k) % N]) begin
        found = 1'b1;
        idx   = TID_W'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/tsk_table.sv
module tsk_table
  import tsk_pkg::*;
#(
  parameter int N        = 4,
  parameter int TID_W    = 2,
  parameter int BUDGET_W = 8,
  parameter int INFO_W   = 16,
  parameter int SID_W    = 4,
  parameter int SLOTS    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [TID_W-1:0]    cfg_task,
  input  logic [1:0]          cfg_fld,
  input  logic [INFO_W-1:0]   cfg_wdata,
  input  logic                upd_valid,
  input  logic [SID_W-1:0]    upd_sid,
  input  logic [N-1:0]        fb_blk,
  input  logic [N-1:0]        fb_err,
  input  logic [TID_W-1:0]    bud_idx,
  output logic [BUDGET_W-1:0] bud_q,
  input  logic [TID_W-1:0]    info_idx,
  output logic [INFO_W-1:0]   info_q,
  output logic [N-1:0]        elig_nxt
);
  localparam int SW = SLOTS * SID_W;

  logic [BUDGET_W-1:0] bud_mem  [N];
  logic [INFO_W-1:0]   info_mem [N];
  logic [SW-1:0]       sid_mem  [N];

  logic [N-1:0] en_q, blk_q, en_nxt, blk_nxt, upd_hit, ctrl_hit;
  tsk_fld_e fld;
  assign fld = tsk_fld_e'(cfg_fld);

  // field storage, no reset, one write port
  always_ff @(posedge clk) begin
    if (cfg_we) begin
      case (fld)
        FLD_BUDGET:  bud_mem[cfg_task]  <= cfg_wdata[BUDGET_W-1:0];
        FLD_INFO:    info_mem[cfg_task] <= cfg_wdata;
        FLD_STREAMS: sid_mem[cfg_task]  <= cfg_wdata[SW-1:0];
        default: ;
      endcase
    end
  end

  assign bud_q  = bud_mem[bud_idx];
  assign info_q = info_mem[info_idx];

  genvar gi, gs;
  generate
    for (gi = 0; gi < N; gi++) begin : g_task
      logic [SLOTS-1:0] slot_eq;
      for (gs = 0; gs < SLOTS; gs++) begin : g_slot
        assign slot_eq[gs] = (sid_mem[gi][gs*SID_W +: SID_W] == upd_sid);
      end
      assign upd_hit[gi]  = upd_valid && (|slot_eq);
      assign ctrl_hit[gi] = cfg_we && (fld == FLD_CTRL) && (cfg_task == TID_W'(gi));
      assign en_nxt[gi]   = (ctrl_hit[gi] ? cfg_wdata[0] : en_q[gi]) && !fb_err[gi];
      assign blk_nxt[gi]  = (blk_q[gi] && !upd_hit[gi] && !ctrl_hit[gi]) || fb_blk[gi];

      p_blk_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_q[gi]) |-> $past(fb_blk[gi]));
      p_blk_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(blk_q[gi]) |-> $past(upd_hit[gi] || ctrl_hit[gi]));
      p_en_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q[gi]) |-> $past(fb_err[gi] || ctrl_hit[gi]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      blk_q <= '0;
    end else begin
      en_q  <= en_nxt;
      blk_q <= blk_nxt;
    end
  end

  assign elig_nxt = en_nxt & ~blk_nxt;
endmodule

// File: rtl/coop_task_sched.sv
module coop_task_sched #(
  parameter int NUM_TASKS = 4,
  parameter int BUDGET_W  = 8,
  parameter int INFO_W    = 16,
  parameter int SID_W     = 4,
  parameter int SLOTS     = 2,
  parameter int TID_W     = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [TID_W-1:0]  cfg_task,
  input  logic [1:0]        cfg_fld,
  input  logic [INFO_W-1:0] cfg_wdata,
  input  logic              upd_valid,
  input  logic [SID_W-1:0]  upd_sid,
  input  logic              req,
  input  logic              req_blocked,
  input  logic              req_error,
  output logic              rsp_valid,
  output logic              rsp_idle,
  output logic [TID_W-1:0]  rsp_task,
  output logic [INFO_W-1:0] rsp_info
);
  localparam logic [TID_W-1:0] LAST_ID = TID_W'(NUM_TASKS - 1);

  logic                cur_vld;
  logic [TID_W-1:0]    cur_id;
  logic [BUDGET_W-1:0] cnt;

  logic [NUM_TASKS-1:0] fb_blk, fb_err, elig_nxt;
  logic [BUDGET_W-1:0]  bud_q;
  logic [INFO_W-1:0]    info_q;
  logic                 pick_ok, stay;
  logic [TID_W-1:0]     pick_id, info_idx;

  // feedback targets only the task granted last
  always_comb begin
    fb_blk = '0;
    fb_err = '0;
    if (req && cur_vld) begin
      fb_blk[cur_id] = req_blocked;
      fb_err[cur_id] = req_error;
    end
  end

  tsk_table #(
    .N(NUM_TASKS), .TID_W(TID_W), .BUDGET_W(BUDGET_W),
    .INFO_W(INFO_W), .SID_W(SID_W), .SLOTS(SLOTS)
  ) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
    .upd_valid(upd_valid), .upd_sid(upd_sid),
    .fb_blk(fb_blk), .fb_err(fb_err),
    .bud_idx(pick_id), .bud_q(bud_q),
    .info_idx(info_idx), .info_q(info_q),
    .elig_nxt(elig_nxt)
  );

  tsk_rr_pick #(.N(NUM_TASKS), .TID_W(TID_W)) u_pick (
    .mask(elig_nxt), .last(cur_id), .found(pick_ok), .idx(pick_id)
  );

  assign stay     = cur_vld && !req_blocked && !req_error
                    && elig_nxt[cur_id] && (cnt != '0);
  assign info_idx = stay ? cur_id : pick_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vld   <= 1'b0;
      cur_id    <= LAST_ID;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_idle  <= 1'b0;
      rsp_task  <= '0;
      rsp_info  <= '0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        if (stay) begin
          cnt      <= cnt - 1'b1;
          rsp_idle <= 1'b0;
          rsp_task <= cur_id;
          rsp_info <= info_q;
        end else if (pick_ok) begin
          cur_vld  <= 1'b1;
          cur_id   <= pick_id;
          cnt      <= (bud_q == '0) ? '0 : bud_q - 1'b1;
          rsp_idle <= 1'b0;
          rsp_task <= pick_id;
          rsp_info <= info_q;
        end else begin
          cur_vld  <= 1'b0;
          rsp_idle <= 1'b1;
          rsp_task <= '0;
          rsp_info <= '0;
        end
      end
    end
  end

  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req));
  p_req_answered_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_idle) |-> (rsp_task == '0 && rsp_info == '0 && !cur_vld));
  p_grant_current_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_idle) |-> (cur_vld && rsp_task == cur_id));
endmodule

// File: tb/sim_coop_task_sched.sv
module sim_coop_task_sched;
  localparam int TID_W  = 2;
  localparam int INFO_W = 16;
  localparam int SID_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [TID_W-1:0] cfg_task = '0;
  logic [1:0] cfg_fld = '0;
  logic [INFO_W-1:0] cfg_wdata = '0;
  logic upd_valid = 1'b0;
  logic [SID_W-1:0] upd_sid = '0;
  logic req = 1'b0, req_blocked = 1'b0, req_error = 1'b0;
  logic rsp_valid, rsp_idle;
  logic [TID_W-1:0] rsp_task;
  logic [INFO_W-1:0] rsp_info;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  coop_task_sched u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .upd_valid(upd_valid), .upd_sid(upd_sid), .req(req),
    .req_blocked(req_blocked), .req_error(req_error), .rsp_valid(rsp_valid),
    .rsp_idle(rsp_idle), .rsp_task(rsp_task), .rsp_info(rsp_info)
  );

  // vector: [5]=blocked [4]=error [3]=expect idle [1:0]=expect task
  localparam logic [5:0] VEC [14] = '{
    6'b00_0_0_00, 6'b00_0_0_00, 6'b00_0_0_01, 6'b00_0_0_10,
    6'b00_0_0_11, 6'b00_0_0_11, 6'b00_0_0_11, 6'b00_0_0_00,
    6'b10_0_0_01, 6'b01_0_0_10, 6'b00_0_0_11, 6'b10_0_0_10,
    6'b10_1_0_00, 6'b00_1_0_00
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int t, input int f, input logic [INFO_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_task = TID_W'(t); cfg_fld = 2'(f); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic upd(input int sid);
    @(negedge clk);
    upd_valid = 1'b1; upd_sid = SID_W'(sid);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_req(input bit b, input bit e, input bit x_idle, input int x_task,
                        input logic [INFO_W-1:0] x_info, input string tag);
    @(negedge clk);
    req = 1'b1; req_blocked = b; req_error = e;
    @(negedge clk);
    chk(rsp_valid == 1'b1, {tag, " R2 valid"}, 32'(rsp_valid), 1);
    chk(rsp_idle == x_idle, {tag, " idle"}, 32'(rsp_idle), 32'(x_idle));
    chk(rsp_task == TID_W'(x_task), {tag, " task"}, 32'(rsp_task), 32'(x_task));
    chk(rsp_info == x_info, {tag, " R9 info"}, 32'(rsp_info), 32'(x_info));
    req = 1'b0; req_blocked = 1'b0; req_error = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " R2 single"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
    do_req(0, 0, 1, 0, 16'h0, "R1 all disabled");

    // R11 field codes used for setup
    for (int t = 0; t < 4; t++) begin
      cfg(t, 1, (t == 0) ? 16'd2 : (t == 1) ? 16'd1 : (t == 2) ? 16'd0 : 16'd3);
      cfg(t, 2, 16'hA000 + 16'(t));
      cfg(t, 3, 16'(((2 * t + 1) << SID_W) | (2 * t)));
      cfg(t, 0, 16'h0001);
    end

    for (int v = 0; v < 14; v++) begin
      do_req(VEC[v][5], VEC[v][4], VEC[v][3], int'(VEC[v][1:0]),
             VEC[v][3] ? 16'h0 : (16'hA000 + 16'(VEC[v][1:0])),
             $sformatf("R3 R4 R5 R7 R8 R11 vec%0d", v));
    end

    upd(9);
    do_req(0, 0, 1, 0, 16'h0, "R6 unrelated stream");
    upd(6);
    do_req(0, 0, 0, 3, 16'hA003, "R5 R8 unblocked resume after last");
    upd(1);
    do_req(0, 0, 0, 3, 16'hA003, "R4 keeps budget");
    cfg(3, 0, 16'h0000);
    do_req(0, 0, 0, 0, 16'hA000, "R10 disabled mid budget");
    cfg(0, 2, 16'h5A5A);
    do_req(0, 0, 0, 0, 16'h5A5A, "R9 rewritten info");
    cfg(1, 0, 16'h0001);
    do_req(0, 0, 0, 1, 16'hA001, "R7 re-enabled");
    cfg(0, 0, 16'h0000);
    do_req(0, 0, 0, 1, 16'hA001, "R4 sole task regranted");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule